// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block produces the strobes that an 8-bit controller core uses to reach external memory. It divides the oscillator clock into machine cycles of twelve clocks, made of six states of two clocks each. In every cycle it drives an address-latch pulse and an active-low read strobe for program memory. When the core is fetching code from external program memory, the read strobe fires twice per cycle. When an external data access is under way, the block drops selected pulses so that the data transfer can use the bus.

The block also qualifies the raw reset pin. A reset only counts once the pin has stayed high for two whole machine cycles. The qualified reset is released on the first clock edge at which the pin is seen low, and that same edge captures the external-access pin. That captured value then fixes the program-memory mode until the next reset. A control bit can restrict the address-latch pulse so that it appears only in data-access cycles.

The core drives three inputs: `ext_fetch`, `movx_req` and `ale_restrict`. All three are sampled once per machine cycle, at the clock edge that ends clock 11, and at the edge that releases reset. The sampled values govern the whole of the following cycle.

Top module: `bus_strobe_seq`

## Requirements
- R1: In a cycle that is not a data cycle, with `ale_restrict` sampled 0, `ale` is high during clocks 0-1 and 6-7 of the 12-clock cycle and low during all other clocks. This gives one pulse every six clocks.
- R2: While the program strobe is enabled, `psen_n` is low during clocks 3-5 and 9-11 of a cycle that is not a data cycle, and high during all other clocks. The strobe is enabled when `ext_fetch` was sampled 1 or `ext_mode` is 1.
- R3: When `ext_fetch` was sampled 0 and `ext_mode` is 0 (fetch from internal program memory), `psen_n` stays high for the whole cycle.
- R4: When `movx_req` is sampled 1, the following cycle is a data cycle. In a data cycle `ale` pulses only at clocks 0-1, so the clock-6 pulse is omitted. Both `psen_n` pulses are also omitted, so `psen_n` stays high for all 12 clocks.
- R5: When `ale_restrict` is sampled 1, `ale` stays low for a whole non-data cycle. A data cycle still produces its clock 0-1 pulse.
- R6: Changes on `ext_fetch`, `movx_req` and `ale_restrict` between two sampling edges have no effect on the current cycle.
- R7: `core_rst` rises only after `rst_pin` has been sampled high on 24 consecutive clock edges. It rises at the 24th edge. A high pulse on `rst_pin` that lasts 23 edges leaves `core_rst` low.
- R8: `core_rst` falls on the first edge at which `rst_pin` is sampled low. The clock that follows that edge is clock 0 of a new cycle.
- R9: While `core_rst` is high, `ale` is low and `psen_n` is high.
- R10: `ext_mode` takes the inverse of `ea_pin` at the edge that releases reset, so `ea_pin` low selects external program memory. `ext_mode` then ignores `ea_pin` until the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset pin, active high |
| ea_pin | input | 1 | External-access pin; low selects external program memory |
| ext_fetch | input | 1 | Current fetch targets external program memory |
| movx_req | input | 1 | Request for an external data-access cycle |
| ale_restrict | input | 1 | When 1, the address-latch pulse appears only in data cycles |
| ale | output | 1 | Address-latch-enable pulse |
| psen_n | output | 1 | Program-store read strobe, active low |
| core_rst | output | 1 | Qualified reset for the core |
| ext_mode | output | 1 | Latched external-program-memory mode |

## Verification
The bench uses the default parameters: two clocks per state, six states per cycle and two reset cycles. This gives a 12-clock machine cycle and a 24-edge reset qualification window. With these values the 23-edge and 24-edge reset boundary can be reached in a few dozen clocks. All four combinations of data-cycle request and latch restriction can be exercised within a few hundred clocks, under both latched access modes.

// File: rtl/bss_pkg.sv
`timescale 1ns/1ps
package bss_pkg;

  // Position inside one half of a machine cycle.
  function automatic int unsigned half_pos(int unsigned ph, int unsigned half);
    return ph % half;
  endfunction

  // Address-latch window: first state of each half cycle.
  function automatic logic ale_slot(int unsigned ph, int unsigned cps, int unsigned half);
    return half_pos(ph, half) < cps;
  endfunction

  // Program strobe window: from mid second state to the end of the half cycle.
  function automatic logic psen_slot(int unsigned ph, int unsigned cps, int unsigned half);
    return half_pos(ph, half) >= (cps + cps / 2);
  endfunction

  function automatic logic second_half(int unsigned ph, int unsigned half);
    return ph >= half;
  endfunction

endpackage

// File: rtl/bss_rst_qual.sv
`timescale 1ns/1ps
module bss_rst_qual #(
  parameter int QUAL_CLKS = 24
) (
  input  logic clk,
  input  logic rst_pin,
  input  logic ea_pin,
  output logic core_rst,
  output logic ext_mode
);
  localparam int CW = $clog2(QUAL_CLKS + 1);
  localparam logic [CW-1:0] CNT_TOP = CW'(QUAL_CLKS - 1);

  logic [CW-1:0] hi_cnt;
  logic          qual_hit;

  assign qual_hit = (hi_cnt == CNT_TOP);

  always_ff @(posedge clk) begin
    if (rst_pin) begin
      hi_cnt   <= qual_hit ? hi_cnt : hi_cnt + 1'b1;
      core_rst <= core_rst | qual_hit;
    end else begin
      hi_cnt   <= '0;
      core_rst <= 1'b0;
      if (core_rst) ext_mode <= ~ea_pin;
    end
  end

  // R7
  rst_rise_needs_pin_chk: assert property (@(posedge clk) disable iff (!rst_pin)
    $rose(core_rst) |-> ($past(rst_pin, 1) && $past(rst_pin, 2)));

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (core_rst)
    !core_rst |=> $stable(ext_mode));

endmodule

// File: rtl/bss_phase_ctr.sv
`timescale 1ns/1ps
module bss_phase_ctr #(
  parameter int CYC_LEN = 12
) (
  input  logic                       clk,
  input  logic                       core_rst,
  output logic [$clog2(CYC_LEN)-1:0] phase,
  output logic                       cyc_last
);
  localparam int PW = $clog2(CYC_LEN);
  localparam logic [PW-1:0] LAST = PW'(CYC_LEN - 1);

  assign cyc_last = (phase == LAST);

  always_ff @(posedge clk) begin
    if (core_rst || cyc_last) phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  // R1
  phase_wrap_chk: assert property (@(posedge clk) disable iff (core_rst)
    cyc_last |=> (phase == '0));

endmodule

// File: rtl/bss_strobe_gen.sv
`timescale 1ns/1ps
module bss_strobe_gen
  import bss_pkg::*;
#(
  parameter int CLKS_PER_STATE   = 2,
  parameter int STATES_PER_CYCLE = 6
) (
  input  logic                                                 clk,
  input  logic                                                 core_rst,
  input  logic [$clog2(CLKS_PER_STATE*STATES_PER_CYCLE)-1:0]   phase,
  input  logic                                                 cyc_last,
  input  logic                                                 ext_mode,
  input  logic                                                 ext_fetch,
  input  logic                                                 movx_req,
  input  logic                                                 ale_restrict,
  output logic                                                 ale,
  output logic                                                 psen_n,
  output logic                                                 data_cyc
);
  localparam int unsigned CYC_LEN = CLKS_PER_STATE * STATES_PER_CYCLE;
  localparam int unsigned HALF    = CYC_LEN / 2;
  localparam int unsigned CPS     = CLKS_PER_STATE;

  logic fetch_ext_q, restrict_q, data_q;
  logic ale_win, psen_win, late_half, psen_en;

  // Cycle controls are captured once per machine cycle.
  always_ff @(posedge clk) begin
    if (core_rst || cyc_last) begin
      fetch_ext_q <= ext_fetch;
      restrict_q  <= ale_restrict;
      data_q      <= movx_req;
    end
  end

  assign ale_win   = ale_slot(32'(phase), CPS, HALF);
  assign psen_win  = psen_slot(32'(phase), CPS, HALF);
  assign late_half = second_half(32'(phase), HALF);
  assign psen_en   = fetch_ext_q | ext_mode;
  assign data_cyc  = data_q & ~core_rst;

  assign ale    = ~core_rst & ale_win & (~restrict_q | data_q) & ~(data_q & late_half);
  assign psen_n = ~(~core_rst & psen_win & psen_en & ~data_q);

  // R4
  data_no_psen_chk: assert property (@(posedge clk) disable iff (core_rst)
    data_cyc |-> psen_n);

  // R3
  psen_needs_enable_chk: assert property (@(posedge clk) disable iff (core_rst)
    !psen_n |-> psen_en);

endmodule

// File: rtl/bus_strobe_seq.sv
`timescale 1ns/1ps
module bus_strobe_seq #(
  parameter int CLKS_PER_STATE   = 2,
  parameter int STATES_PER_CYCLE = 6,
  parameter int RESET_CYCLES     = 2
) (
  input  logic clk,
  input  logic rst_pin,
  input  logic ea_pin,
  input  logic ext_fetch,
  input  logic movx_req,
  input  logic ale_restrict,
  output logic ale,
  output logic psen_n,
  output logic core_rst,
  output logic ext_mode
);
  localparam int CYC_LEN   = CLKS_PER_STATE * STATES_PER_CYCLE;
  localparam int QUAL_CLKS = RESET_CYCLES * CYC_LEN;
  localparam int PW        = $clog2(CYC_LEN);
  localparam int HALF      = CYC_LEN / 2;

  logic [PW-1:0] phase;
  logic          cyc_last;
  logic          data_cyc;

  bss_rst_qual #(.QUAL_CLKS(QUAL_CLKS)) u_rst (
    .clk(clk), .rst_pin(rst_pin), .ea_pin(ea_pin),
    .core_rst(core_rst), .ext_mode(ext_mode)
  );

  bss_phase_ctr #(.CYC_LEN(CYC_LEN)) u_phase (
    .clk(clk), .core_rst(core_rst), .phase(phase), .cyc_last(cyc_last)
  );

  bss_strobe_gen #(
    .CLKS_PER_STATE(CLKS_PER_STATE), .STATES_PER_CYCLE(STATES_PER_CYCLE)
  ) u_strobe (
    .clk(clk), .core_rst(core_rst), .phase(phase), .cyc_last(cyc_last),
    .ext_mode(ext_mode), .ext_fetch(ext_fetch), .movx_req(movx_req),
    .ale_restrict(ale_restrict), .ale(ale), .psen_n(psen_n), .data_cyc(data_cyc)
  );

  // R9
  quiet_in_reset_chk: assert property (@(posedge clk)
    core_rst |-> (!ale && psen_n));

  // R1
  ale_start_chk: assert property (@(posedge clk) disable iff (core_rst)
    $rose(ale) |-> (phase == '0 || phase == PW'(HALF)));

  // R8
  release_phase_chk: assert property (@(posedge clk) disable iff (rst_pin)
    $fell(core_rst) |-> (phase == '0));

endmodule

// File: tb/bus_strobe_seq_bench.sv
`timescale 1ns/1ps
module bus_strobe_seq_bench;

  logic clk = 1'b0;
  logic rst_pin = 1'b1, ea_pin = 1'b1;
  logic ext_fetch = 1'b0, movx_req = 1'b0, ale_restrict = 1'b0;
  logic ale, psen_n, core_rst, ext_mode;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  string cur_tag = "R1";

  typedef struct packed {
    logic ale;
    logic psen_n;
    logic core_rst;
    logic ext_mode;
  } exp_t;

  exp_t sb_q[$];

  always #4 clk = ~clk;

  bus_strobe_seq u_bus_strobe_seq (
    .clk(clk), .rst_pin(rst_pin), .ea_pin(ea_pin), .ext_fetch(ext_fetch),
    .movx_req(movx_req), .ale_restrict(ale_restrict), .ale(ale),
    .psen_n(psen_n), .core_rst(core_rst), .ext_mode(ext_mode)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Expected strobes for clock p of a cycle, written from the requirements.
  function automatic exp_t model(int p, bit movx, bit fetch, bit restr, bit ext);
    exp_t e;
    bit ale_t, psen_t;
    ale_t  = (p < 2) || (p >= 6 && p < 8 && !movx);
    if (restr && !movx) ale_t = 1'b0;
    psen_t = (fetch || ext) && !movx && ((p % 6) >= 3);
    e.ale = ale_t; e.psen_n = !psen_t; e.core_rst = 1'b0; e.ext_mode = ext;
    return e;
  endfunction

  // Driver: called at a negedge just before a cycle-start edge.
  task automatic do_cycle(input bit movx, input bit fetch, input bit restr,
                          input bit ext, input string tag);
    cur_tag = tag;
    movx_req = movx; ext_fetch = fetch; ale_restrict = restr;
    for (int p = 0; p < 12; p++) sb_q.push_back(model(p, movx, fetch, restr, ext));
    repeat (6) @(negedge clk);
    // R6: flip controls mid-cycle; expectations stay as captured.
    movx_req = ~movx; ext_fetch = ~fetch; ale_restrict = ~restr;
    repeat (6) @(negedge clk);
  endtask

  // Monitor: pops one expected item per clock.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(ale == e.ale, {cur_tag, " ale"}, ale, e.ale);
        chk(psen_n == e.psen_n, {cur_tag, " psen_n"}, psen_n, e.psen_n);
        chk(core_rst == e.core_rst, {cur_tag, " R8 core_rst"}, core_rst, e.core_rst);
        chk(ext_mode == e.ext_mode, {cur_tag, " R10 ext_mode"}, ext_mode, e.ext_mode);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R7: qualification boundary from power-up.
    repeat (23) @(posedge clk);
    #2 chk(core_rst == 1'b0, "R7 after 23 high edges", core_rst, 0);
    @(posedge clk);
    #2 chk(core_rst == 1'b1, "R7 after 24 high edges", core_rst, 1);
    // R9: strobes quiet during reset.
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #2;
      chk(ale == 1'b0, "R9 ale in reset", ale, 0);
      chk(psen_n == 1'b1, "R9 psen_n in reset", psen_n, 1);
    end
    // Release with ea_pin high: internal program memory (R10).
    @(negedge clk);
    rst_pin = 1'b0;
    do_cycle(0, 0, 0, 0, "R1/R3");
    do_cycle(0, 1, 0, 0, "R2");
    do_cycle(1, 1, 0, 0, "R4");
    do_cycle(0, 1, 0, 0, "R2 after data");
    do_cycle(0, 1, 1, 0, "R5");
    do_cycle(1, 0, 1, 0, "R5/R4");
    // R10: ea_pin change while running is ignored.
    ea_pin = 1'b0;
    do_cycle(0, 0, 0, 0, "R10/R3");
    do_cycle(1, 0, 0, 0, "R4 internal");
    // R7: a 23-edge pulse does not reset.
    rst_pin = 1'b1;
    for (int k = 0; k < 23; k++) begin
      @(posedge clk); #2;
      chk(core_rst == 1'b0, "R7 short pulse", core_rst, 0);
    end
    @(negedge clk);
    rst_pin = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk); #2;
      chk(core_rst == 1'b0, "R7 short pulse end", core_rst, 0);
      chk(ext_mode == 1'b0, "R10 mode kept", ext_mode, 0);
    end
    // Full reset, release with ea_pin low: external program memory.
    @(negedge clk);
    rst_pin = 1'b1;
    repeat (30) @(negedge clk);
    chk(core_rst == 1'b1, "R7 full reset", core_rst, 1);
    chk(ale == 1'b0 && psen_n == 1'b1, "R9 strobes in reset", {ale, psen_n}, 1);
    rst_pin = 1'b0;
    do_cycle(0, 0, 0, 1, "R10/R2");
    do_cycle(1, 0, 0, 1, "R4 ext");
    do_cycle(0, 0, 1, 1, "R5 ext");
    ea_pin = 1'b1;
    do_cycle(1, 1, 1, 1, "R5/R4 ext");
    do_cycle(0, 1, 0, 1, "R2/R6");
    @(posedge clk); #3;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule